// File: doc/BRIEF.md
# Dual Event-Selectable Performance Counters

This block is a small performance-monitoring unit holding two independent counters. Each counter owns a 16-bit control word that chooses one of sixty-four per-cycle event strobes through a 6-bit code, and that gates counting with two separate bits: an enable and a start. A third control bit is a write-one clear. A fourth bit moves the elapsed-time event from the core clock onto a slower prescaler tick. The elapsed-time event is generated inside the block. All other events arrive as single-cycle strobes on `evt_strobe`.

Software reaches the unit through a single-cycle read/write port. Each count, `CNT_W` bits wide, is read as a high word and a low word. Reading the high word takes a snapshot of the low part, so a high read followed by a low read gives one coherent value even while the counter keeps running. A counter wraps silently, and the unit has no overflow flag or interrupt.

Top module: `dual_perf_counter`

## Requirements
- R1: After a synchronous active-high reset, every register in the map reads as zero and no counter advances.
- R2: Word addresses: control of counter 0 at 0x00 and of counter 1 at 0x04; counter 0 high at 0x10 and low at 0x14; counter 1 high at 0x18 and low at 0x1C. Read data appears on `bus_rdata` in the cycle after `bus_rd` and is held until the next read. Unmapped addresses read zero and ignore writes.
- R3: The control word holds the event code in bits [5:0], the clock-source select in bit 8, start in bit 14 and enable in bit 15, and these read back as written. Every other bit, including the clear bit 13, reads as zero.
- R4: A counter adds one for each cycle in which `evt_strobe[code]` is high, but only while enable and start are both 1. With either bit at 0 the value is held, not reset.
- R5: Writing a control word with bit 13 set zeroes that counter at the same clock edge. This clear overrides an increment in the same cycle and leaves the other counter untouched.
- R6: The codes 0x00, 0x0C, 0x1B to 0x20 inclusive, 0x26 and anything above 0x29 select no event and never advance a counter.
- R7: Code 0x23 is elapsed time and ignores its strobe input. It advances on every clock when bit 8 is 0, and once per `PRESC_DIV` clocks when bit 8 is 1.
- R8: The high register returns count bits [CNT_W-1:LO_W] in its lowest bits with zeros above. The low register returns count bits [LO_W-1:0].
- R9: A high read captures the low part. The next low read of that counter returns the captured part. A low read with no pending capture returns the live value.
- R10: A counter steps from all ones to zero and raises no status of any kind.
- R11: The two counters select, gate, clear and count independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| evt_strobe | input | 64 | Per-cycle event strobes, indexed by event code |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the unit with `CNT_W=12`, `LO_W=8` and `PRESC_DIV=4`. A 12-bit count wraps after 4096 cycles, so the silent wrap can be reached within the run. With an 8-bit low part, carries into the high word happen every 256 cycles, so a high/low pair read across a gap of several hundred cycles shows whether the snapshot holds. A prescaler of four lets a 40-cycle window give an exact tick count, whatever the prescaler phase.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CODE_W   = 6;
  localparam int CTL_W    = 16;
  localparam int EN_BIT   = 15;
  localparam int ST_BIT   = 14;
  localparam int CLR_BIT  = 13;
  localparam int SRC_BIT  = 8;
  localparam logic [CODE_W-1:0] EV_ELAPSED = 6'h23;
  localparam logic [CODE_W-1:0] EV_LAST    = 6'h29;

  typedef struct packed {
    logic              en;
    logic              start;
    logic              src;
    logic [CODE_W-1:0] code;
  } ctl_t;

  // Codes with no event behind them count nothing.
  function automatic logic code_valid(input logic [CODE_W-1:0] c);
    return (c != '0) && (c <= EV_LAST) && (c != 6'h0c) && (c != 6'h26)
           && !((c >= 6'h1b) && (c <= 6'h20));
  endfunction

  function automatic logic [CTL_W-1:0] ctl_word(input ctl_t c);
    logic [CTL_W-1:0] w;
    w = '0;
    w[EN_BIT]     = c.en;
    w[ST_BIT]     = c.start;
    w[SRC_BIT]    = c.src;
    w[CODE_W-1:0] = c.code;
    return w;
  endfunction
endpackage

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || div_q == LAST) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
#(
  parameter int N_EVT = 64
) (
  input  logic [N_EVT-1:0] evt,
  input  ctl_t             ctl,
  input  logic             tick,
  output logic             hit
);
  logic elapsed_step;

  always_comb begin
    elapsed_step = ctl.src ? tick : 1'b1;
    if (!code_valid(ctl.code))          hit = 1'b0;
    else if (ctl.code == EV_ELAPSED)    hit = elapsed_step;
    else                                hit = evt[ctl.code];
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end
endmodule

// File: rtl/dual_perf_counter.sv
module dual_perf_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W     = 48,
  parameter int LO_W      = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int PRESC_DIV = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic [(1<<CODE_W)-1:0]    evt_strobe,
  output logic [DATA_W-1:0]         bus_rdata
);
  localparam int N_CNT = 2;
  localparam int HI_W  = CNT_W - LO_W;
  localparam int N_EVT = 1 << CODE_W;

  logic                        in_ctl, in_cnt;
  ctl_t                        ctl_q [N_CNT];
  logic [N_CNT-1:0]            clr_pulse;
  logic [N_CNT-1:0]            run;
  logic [N_CNT-1:0]            hit;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [LO_W-1:0]             shadow_q [N_CNT];
  logic [N_CNT-1:0]            shadow_vld;
  logic                        tick;
  logic [DATA_W-1:0]           rd_val;
  logic                        unused_wdata;

  // Address decode: control region 0x00/0x04, count region 0x10..0x1C.
  assign in_ctl = (bus_addr[ADDR_W-1:3] == '0) && (bus_addr[1:0] == 2'b00);
  assign in_cnt = (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(1)) && (bus_addr[1:0] == 2'b00);
  assign unused_wdata = &{1'b0, bus_wdata[DATA_W-1:CTL_W], bus_wdata[12:9],
                          bus_wdata[7:CODE_W]};

  pmu_prescaler #(.DIV(PRESC_DIV)) presc_i (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    logic ctl_hit;
    assign ctl_hit      = bus_wr && in_ctl && (bus_addr[2] == 1'(k));
    assign clr_pulse[k] = ctl_hit && bus_wdata[CLR_BIT];
    assign run[k]       = ctl_q[k].en && ctl_q[k].start;

    always_ff @(posedge clk) begin
      if (rst)          ctl_q[k] <= '0;
      else if (ctl_hit) ctl_q[k] <= '{en:    bus_wdata[EN_BIT],
                                      start: bus_wdata[ST_BIT],
                                      src:   bus_wdata[SRC_BIT],
                                      code:  bus_wdata[CODE_W-1:0]};
    end

    pmu_event_sel #(.N_EVT(N_EVT)) sel_i (
      .evt  (evt_strobe),
      .ctl  (ctl_q[k]),
      .tick (tick),
      .hit  (hit[k])
    );

    pmu_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk (clk),
      .rst (rst),
      .clr (clr_pulse[k]),
      .inc (run[k] && hit[k]),
      .q   (cnt_q[k])
    );

    // Snapshot of the low part, taken on a high read.
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q[k]   <= '0;
        shadow_vld[k] <= 1'b0;
      end else if (bus_rd && in_cnt && (bus_addr[3] == 1'(k))) begin
        if (!bus_addr[2]) begin
          shadow_q[k]   <= cnt_q[k][LO_W-1:0];
          shadow_vld[k] <= 1'b1;
        end else begin
          shadow_vld[k] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_ctl) begin
      rd_val[CTL_W-1:0] = ctl_word(ctl_q[bus_addr[2]]);
    end else if (in_cnt) begin
      if (!bus_addr[2])
        rd_val[HI_W-1:0] = cnt_q[bus_addr[3]][CNT_W-1:LO_W];
      else if (shadow_vld[bus_addr[3]])
        rd_val[LO_W-1:0] = shadow_q[bus_addr[3]];
      else
        rd_val[LO_W-1:0] = cnt_q[bus_addr[3]][LO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int CNT_W  = 48,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [1:0]            clr_pulse,
  input logic [1:0]            run,
  input logic [1:0][CNT_W-1:0] cnt_vals
);
  localparam int HI_W = CNT_W - LO_W;

  logic hi_rd, ctl_rd;
  assign hi_rd  = bus_rd && (bus_addr == ADDR_W'(8'h10) || bus_addr == ADDR_W'(8'h18));
  assign ctl_rd = bus_rd && (bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h04));

  for (genvar k = 0; k < 2; k++) begin : g_chk
    // R5: a clear leaves the counter at zero, whatever the event did
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
      clr_pulse[k] |=> (cnt_vals[k] == '0));

    // R4: without run the value is held
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (!clr_pulse[k] && !run[k]) |=> $stable(cnt_vals[k]));

    // R10: steps of at most one, wrapping through zero
    a_r10_step_one: assert property (@(posedge clk) disable iff (rst)
      !clr_pulse[k] |=> (cnt_vals[k] == $past(cnt_vals[k]) ||
                         cnt_vals[k] == $past(cnt_vals[k]) + 1'b1));
  end

  // R8: the high register is zero-extended
  a_r8_hi_zero_ext: assert property (@(posedge clk) disable iff (rst)
    $past(hi_rd) |-> (bus_rdata[DATA_W-1:HI_W] == '0));

  // R3: the clear bit never reads back as one
  a_r3_clr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_rd) |-> (bus_rdata[13] == 1'b0));
endmodule

bind dual_perf_counter pmu_checker #(
  .CNT_W(CNT_W), .LO_W(LO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .clr_pulse (clr_pulse),
  .run       (run),
  .cnt_vals  (cnt_q)
);

// File: tb/dual_perf_counter_tb_top.sv
module dual_perf_counter_tb_top;
  localparam int CNT_W = 12, LO_W = 8, DATA_W = 32, ADDR_W = 5, PRESC = 4;
  localparam logic [4:0] A_CTL0 = 5'h00, A_CTL1 = 5'h04, A_HI0 = 5'h10,
                         A_LO0 = 5'h14, A_HI1 = 5'h18, A_LO1 = 5'h1c;
  localparam logic [31:0] EN = 32'h8000, ST = 32'h4000, CLR = 32'h2000, SRC = 32'h0100;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic [63:0] evt = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_perf_counter #(.CNT_W(CNT_W), .LO_W(LO_W), .DATA_W(DATA_W),
                      .ADDR_W(ADDR_W), .PRESC_DIV(PRESC)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .evt_strobe(evt), .bus_rdata(bus_rdata));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pair(bit k, output logic [31:0] hi, output logic [31:0] lo);
    rd(k ? A_HI1 : A_HI0, hi);
    rd(k ? A_LO1 : A_LO0, lo);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [4:0] addrs [7] = '{A_CTL0, A_CTL1, A_HI0, A_LO0, A_HI1, A_LO1, 5'h08};
    foreach (addrs[i]) begin
      rd(addrs[i], v);
      check("R1 reset value / R2 map", v, 32'h0);
    end
  endtask

  task automatic t_ctl_fields();
    logic [31:0] v;
    wr(A_CTL1, 32'hFFFF_FFFF);
    rd(A_CTL1, v);
    check("R3 control readback", v, 32'h0000_C13F);
    wr(A_CTL1, 32'h0);
    rd(A_CTL1, v);
    check("R3 control cleared", v, 32'h0);
  endtask

  task automatic t_elapsed();
    logic [31:0] hi, lo;
    evt = '0;
    wr(A_CTL0, EN | ST | CLR | 32'h23);
    idle(29);
    wr(A_CTL0, 32'h23);
    rd_pair(0, hi, lo);
    check("R7 elapsed per clock", {hi[23:0], lo[7:0]}, 32'd30);
    idle(50);
    rd_pair(0, hi, lo);
    check("R4 frozen after disable", {hi[23:0], lo[7:0]}, 32'd30);
  endtask

  task automatic t_prescale();
    logic [31:0] hi, lo;
    wr(A_CTL0, EN | ST | SRC | CLR | 32'h23);
    idle(39);
    wr(A_CTL0, 32'h23);
    rd_pair(0, hi, lo);
    check("R7 elapsed per prescaler tick", {hi[23:0], lo[7:0]}, 32'd10);
  endtask

  task automatic t_gating();
    logic [31:0] hi, lo;
    wr(A_CTL0, EN | CLR | 32'h23);
    idle(20);
    wr(A_CTL0, 32'h23);
    rd_pair(0, hi, lo);
    check("R4 enable alone", {hi[23:0], lo[7:0]}, 32'd0);
    wr(A_CTL0, ST | 32'h23);
    idle(20);
    wr(A_CTL0, 32'h23);
    rd_pair(0, hi, lo);
    check("R4 start alone", {hi[23:0], lo[7:0]}, 32'd0);
  endtask

  task automatic t_events();
    logic [31:0] hi, lo;
    wr(A_CTL0, EN | ST | CLR | 32'h11);
    wr(A_CTL1, EN | ST | CLR | 32'h10);
    for (int i = 0; i < 7; i++) begin
      evt[6'h11] = 1'b1; evt[6'h12] = 1'b1; idle(1);
      evt = '0; idle(1);
    end
    for (int i = 0; i < 5; i++) begin
      evt[6'h10] = 1'b1; evt[6'h23] = 1'b1; idle(1);
      evt = '0; idle(1);
    end
    wr(A_CTL0, 32'h11);
    wr(A_CTL1, 32'h10);
    rd_pair(0, hi, lo);
    check("R4 R11 counter 0 selected strobe", {hi[23:0], lo[7:0]}, 32'd7);
    rd_pair(1, hi, lo);
    check("R4 R11 counter 1 selected strobe", {hi[23:0], lo[7:0]}, 32'd5);
  endtask

  task automatic t_clear_isolate();
    logic [31:0] hi, lo;
    wr(A_CTL0, CLR | 32'h11);
    rd_pair(0, hi, lo);
    check("R5 clear zeroes counter 0", {hi[23:0], lo[7:0]}, 32'd0);
    rd_pair(1, hi, lo);
    check("R5 R11 counter 1 untouched", {hi[23:0], lo[7:0]}, 32'd5);
  endtask

  task automatic t_clear_priority();
    logic [31:0] hi, lo;
    wr(A_CTL0, EN | ST | 32'h23);
    idle(10);
    wr(A_CTL0, EN | ST | CLR | 32'h23);
    wr(A_CTL0, 32'h23);
    rd_pair(0, hi, lo);
    check("R5 clear beats increment", {hi[23:0], lo[7:0]}, 32'd1);
  endtask

  task automatic t_reserved();
    logic [31:0] hi, lo;
    logic [5:0] codes [5] = '{6'h0c, 6'h1e, 6'h26, 6'h00, 6'h2a};
    foreach (codes[i]) begin
      wr(A_CTL1, EN | ST | CLR | 32'(codes[i]));
      evt = '1; idle(20); evt = '0;
      wr(A_CTL1, 32'h0);
      rd_pair(1, hi, lo);
      check("R6 reserved code counts nothing", {hi[23:0], lo[7:0]}, 32'd0);
    end
  endtask

  task automatic t_wrap();
    logic [31:0] hi, lo;
    wr(A_CTL0, EN | ST | CLR | 32'h23);
    idle(4096 + 9);
    wr(A_CTL0, 32'h23);
    rd_pair(0, hi, lo);
    check("R10 silent wrap high", hi, 32'd0);
    check("R10 R8 silent wrap low", lo, 32'd10);
  endtask

  task automatic t_coherent();
    logic [31:0] h1, l1, h2, l2, a, b;
    logic [11:0] v1, v2;
    wr(A_CTL0, EN | ST | CLR | 32'h23);
    idle(500);
    rd(A_HI0, h1);
    idle(300);
    rd(A_LO0, l1);
    rd(A_HI0, h2);
    rd(A_LO0, l2);
    check("R8 high word zero-extended", h1 >> 4, 32'd0);
    v1 = {h1[3:0], l1[7:0]};
    v2 = {h2[3:0], l2[7:0]};
    check("R9 snapshot coherence", 32'(v2 - v1), 32'd302);
    rd(A_LO0, a);
    idle(20);
    rd(A_LO0, b);
    check("R9 live low read", 32'(8'(b[7:0] - a[7:0])), 32'd21);
    wr(A_CTL0, 32'h23);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_ctl_fields();
    t_elapsed();
    t_prescale();
    t_gating();
    t_events();
    t_clear_isolate();
    t_clear_priority();
    t_reserved();
    t_wrap();
    t_coherent();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule